// File: doc/BRIEF.md
# Verified-Result Reuse Table

This block is a direct-mapped table of computations whose results have already been verified at commit. A later instruction with the same opcode and the same two operand values can be checked against the stored outcome. The table does not run a second copy of the computation. The functional unit still computes its own result in parallel. A surrounding fault-detection stage compares that result with the outcome the table returns.

The table has two ports. The lookup port is used at execute time, once both operands are known. It takes an instruction class, an opcode and two operand values, and one cycle later it returns a done strobe, a hit flag and the stored outcome. The registration port is used at commit. It writes the opcode, both operands and the verified outcome into the slot selected by the operand hash. That write replaces whatever the slot held. Branches take no part in either port. Loads and stores take part with their address computation as the recorded outcome.

Top module: `vres_table`

## Requirements
- R1: A synchronous reset clears every entry, so after reset every lookup misses, and `lk_done` is low during reset and in the first cycle after it.
- R2: Every lookup request (`lk_valid` high at a rising edge) gives `lk_done` high exactly one cycle later, whatever its class. With no request, `lk_done` is low in the next cycle.
- R3: The slot index is the low IDX_W bits of `a XOR (NOT b)`. Operand pairs whose indices differ occupy separate slots and can both hit at the same time.
- R4: A lookup hits only if its slot is valid and the stored opcode, first operand and second operand all equal the request exactly. On a hit, `lk_result` is the outcome that was registered.
- R5: When `lk_done` is high and `lk_hit` is low, `lk_result` is zero.
- R6: Instruction class encoding: 0 = register-writing ALU, 1 = load (address), 2 = store (address), 3 = branch. A registration (`rg_valid` high) is stored for classes 0, 1 and 2. A registration of class 3 leaves the table unchanged.
- R7: A lookup of class 3 always misses, even when a matching entry is stored.
- R8: A registration replaces the entry at its index, so an earlier entry whose operands alias to the same index then misses.
- R9: If a lookup and a registration hit the same index in the same cycle, the lookup returns the contents from before the write. The new entry is seen from the next lookup onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request strobe |
| lk_kind | input | 2 | Lookup instruction class (R6 encoding) |
| lk_opc | input | OPC_W | Lookup opcode |
| lk_a | input | DATA_W | Lookup first operand |
| lk_b | input | DATA_W | Lookup second operand |
| lk_done | output | 1 | Lookup answer valid, one cycle after request |
| lk_hit | output | 1 | Stored matching outcome found |
| lk_result | output | DATA_W | Stored outcome on hit, zero otherwise |
| rg_valid | input | 1 | Registration strobe at commit |
| rg_kind | input | 2 | Registration instruction class |
| rg_opc | input | OPC_W | Registered opcode |
| rg_a | input | DATA_W | Registered first operand |
| rg_b | input | DATA_W | Registered second operand |
| rg_result | input | DATA_W | Verified outcome to store |

## Verification
The assertions assume that the reset is held long enough to be seen at a clock edge, and that the class inputs carry only the four defined codes. Every lookup and registration input is treated as meaningful only in cycles where its strobe is high. The stimulus drives all inputs half a cycle away from the active edge and uses only the codes 0 to 3. It draws operands from small pools so that aliasing, exact repeats and near misses all occur often in a 64-slot instance.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_LOAD   = 2'd1,
    K_STORE  = 2'd2,
    K_BRANCH = 2'd3
  } op_kind_e;

  // Classes that take part in the table: everything except branches.
  function automatic logic kind_takes_part(input op_kind_e k);
    return (k != K_BRANCH);
  endfunction

endpackage

// File: rtl/vrt_hash.sv
module vrt_hash #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] a_lo,
  input  logic [IDX_W-1:0] b_lo,
  output logic [IDX_W-1:0] idx
);

  // Slot selection: first operand XOR inverted second operand.
  function automatic logic [IDX_W-1:0] mix(input logic [IDX_W-1:0] x,
                                           input logic [IDX_W-1:0] y);
    return x ^ ~y;
  endfunction

  assign idx = mix(a_lo, b_lo);

endmodule

// File: rtl/vrt_array.sv
module vrt_array #(
  parameter int OPC_W  = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OPC_W-1:0]  wr_opc,
  input  logic [DATA_W-1:0] wr_a,
  input  logic [DATA_W-1:0] wr_b,
  input  logic [DATA_W-1:0] wr_res,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld_q,
  output logic [OPC_W-1:0]  rd_opc_q,
  output logic [DATA_W-1:0] rd_a_q,
  output logic [DATA_W-1:0] rd_b_q,
  output logic [DATA_W-1:0] rd_res_q
);

  localparam int SLOTS = 1 << IDX_W;

  logic [SLOTS-1:0]  vld_q;
  logic [OPC_W-1:0]  opc_mem [SLOTS];
  logic [DATA_W-1:0] a_mem   [SLOTS];
  logic [DATA_W-1:0] b_mem   [SLOTS];
  logic [DATA_W-1:0] res_mem [SLOTS];

  // Valid bits carry the reset; payload arrays do not need it.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      if (rd_en) rd_vld_q <= vld_q[rd_idx];
      if (wr_en) vld_q[wr_idx] <= 1'b1;
    end
  end

  // Read before write: a same-slot read in the write cycle sees old data.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_opc_q <= opc_mem[rd_idx];
      rd_a_q   <= a_mem[rd_idx];
      rd_b_q   <= b_mem[rd_idx];
      rd_res_q <= res_mem[rd_idx];
    end
    if (wr_en) begin
      opc_mem[wr_idx] <= wr_opc;
      a_mem[wr_idx]   <= wr_a;
      b_mem[wr_idx]   <= wr_b;
      res_mem[wr_idx] <= wr_res;
    end
  end

  // R8
  slot_filled_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/vrt_match.sv
module vrt_match #(
  parameter int OPC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_fire,
  input  logic              req_ok,
  input  logic [OPC_W-1:0]  req_opc,
  input  logic [DATA_W-1:0] req_a,
  input  logic [DATA_W-1:0] req_b,
  input  logic              ent_vld,
  input  logic [OPC_W-1:0]  ent_opc,
  input  logic [DATA_W-1:0] ent_a,
  input  logic [DATA_W-1:0] ent_b,
  input  logic [DATA_W-1:0] ent_res,
  output logic              done,
  output logic              hit,
  output logic [DATA_W-1:0] result
);

  logic              pend_q;
  logic              ok_q;
  logic [OPC_W-1:0]  opc_q;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;
  logic              tag_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      pend_q <= req_fire;
      ok_q   <= req_fire & req_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (req_fire) begin
      opc_q <= req_opc;
      a_q   <= req_a;
      b_q   <= req_b;
    end
  end

  function automatic logic same_key(input logic [OPC_W-1:0]  o1,
                                    input logic [DATA_W-1:0] x1,
                                    input logic [DATA_W-1:0] y1,
                                    input logic [OPC_W-1:0]  o2,
                                    input logic [DATA_W-1:0] x2,
                                    input logic [DATA_W-1:0] y2);
    return (o1 == o2) && (x1 == x2) && (y1 == y2);
  endfunction

  assign tag_eq = same_key(opc_q, a_q, b_q, ent_opc, ent_a, ent_b);
  assign done   = pend_q;
  assign hit    = pend_q & ok_q & ent_vld & tag_eq;
  assign result = hit ? ent_res : '0;

  // R2
  answer_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_fire |=> done);

  // R4
  hit_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> done);

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !hit) |-> (result == '0));

endmodule

// File: rtl/vres_table.sv
module vres_table #(
  parameter int OPC_W  = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [1:0]        lk_kind,
  input  logic [OPC_W-1:0]  lk_opc,
  input  logic [DATA_W-1:0] lk_a,
  input  logic [DATA_W-1:0] lk_b,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_result,
  input  logic              rg_valid,
  input  logic [1:0]        rg_kind,
  input  logic [OPC_W-1:0]  rg_opc,
  input  logic [DATA_W-1:0] rg_a,
  input  logic [DATA_W-1:0] rg_b,
  input  logic [DATA_W-1:0] rg_result
);
  import vrt_pkg::*;

  op_kind_e          lk_kind_e;
  op_kind_e          rg_kind_e;
  logic              wr_fire;
  logic              rd_eligible;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic              ent_vld;
  logic [OPC_W-1:0]  ent_opc;
  logic [DATA_W-1:0] ent_a;
  logic [DATA_W-1:0] ent_b;
  logic [DATA_W-1:0] ent_res;

  assign lk_kind_e   = op_kind_e'(lk_kind);
  assign rg_kind_e   = op_kind_e'(rg_kind);
  assign wr_fire     = rg_valid & kind_takes_part(rg_kind_e);
  assign rd_eligible = kind_takes_part(lk_kind_e);

  vrt_hash #(.IDX_W(IDX_W)) u_rd_hash (
    .a_lo(lk_a[IDX_W-1:0]), .b_lo(lk_b[IDX_W-1:0]), .idx(rd_idx)
  );

  vrt_hash #(.IDX_W(IDX_W)) u_wr_hash (
    .a_lo(rg_a[IDX_W-1:0]), .b_lo(rg_b[IDX_W-1:0]), .idx(wr_idx)
  );

  vrt_array #(.OPC_W(OPC_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst(rst),
    .wr_en(wr_fire), .wr_idx(wr_idx), .wr_opc(rg_opc),
    .wr_a(rg_a), .wr_b(rg_b), .wr_res(rg_result),
    .rd_en(lk_valid), .rd_idx(rd_idx),
    .rd_vld_q(ent_vld), .rd_opc_q(ent_opc), .rd_a_q(ent_a),
    .rd_b_q(ent_b), .rd_res_q(ent_res)
  );

  vrt_match #(.OPC_W(OPC_W), .DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst),
    .req_fire(lk_valid), .req_ok(rd_eligible),
    .req_opc(lk_opc), .req_a(lk_a), .req_b(lk_b),
    .ent_vld(ent_vld), .ent_opc(ent_opc), .ent_a(ent_a),
    .ent_b(ent_b), .ent_res(ent_res),
    .done(lk_done), .hit(lk_hit), .result(lk_result)
  );

  // R7
  branch_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_kind == 2'd3) |=> !lk_hit);

  // R2
  idle_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !lk_done);

  // R4
  hit_same_opc_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!lk_hit || ent_opc == $past(lk_opc)));

endmodule

// File: tb/vres_table_tb.sv
module vres_table_tb;
  localparam int OPC_W  = 6;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;
  localparam int SLOTS  = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lk_valid = 1'b0;
  logic [1:0]        lk_kind = '0;
  logic [OPC_W-1:0]  lk_opc = '0;
  logic [DATA_W-1:0] lk_a = '0, lk_b = '0;
  logic              lk_done, lk_hit;
  logic [DATA_W-1:0] lk_result;
  logic              rg_valid = 1'b0;
  logic [1:0]        rg_kind = '0;
  logic [OPC_W-1:0]  rg_opc = '0;
  logic [DATA_W-1:0] rg_a = '0, rg_b = '0, rg_result = '0;

  int errors = 0;
  int checks = 0;

  // Model of the table
  bit                m_vld [SLOTS];
  logic [OPC_W-1:0]  m_opc [SLOTS];
  logic [DATA_W-1:0] m_a   [SLOTS];
  logic [DATA_W-1:0] m_b   [SLOTS];
  logic [DATA_W-1:0] m_res [SLOTS];

  // Pending expectation for the next cycle
  bit                e_done = 1'b0;
  bit                e_hit  = 1'b0;
  logic [DATA_W-1:0] e_res  = '0;
  string             e_tag  = "R1";

  always #2 clk = ~clk;

  vres_table #(.OPC_W(OPC_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_opc(lk_opc),
    .lk_a(lk_a), .lk_b(lk_b),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_result(lk_result),
    .rg_valid(rg_valid), .rg_kind(rg_kind), .rg_opc(rg_opc),
    .rg_a(rg_a), .rg_b(rg_b), .rg_result(rg_result)
  );

  // Slot index written as the complement of a plain XOR.
  function automatic int tb_slot(input logic [DATA_W-1:0] a,
                                 input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] t;
    t = ~(a ^ b);
    return int'(t[IDX_W-1:0]);
  endfunction

  task automatic check_pending();
    checks++;
    if (lk_done !== e_done || lk_hit !== e_hit || lk_result !== e_res) begin
      errors++;
      $display("FAIL %s: done/hit/result got %0b/%0b/%h expected %0b/%0b/%h",
               e_tag, lk_done, lk_hit, lk_result, e_done, e_hit, e_res);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < SLOTS; i++) m_vld[i] = 1'b0;
  endtask

  task automatic step(input bit lv, input logic [1:0] lk, input logic [OPC_W-1:0] lo,
                      input logic [DATA_W-1:0] la, input logic [DATA_W-1:0] lb,
                      input bit rv, input logic [1:0] rk, input logic [OPC_W-1:0] ro,
                      input logic [DATA_W-1:0] ra, input logic [DATA_W-1:0] rb,
                      input logic [DATA_W-1:0] rr, input string tag);
    int s;
    @(negedge clk);
    check_pending();
    s = tb_slot(la, lb);
    e_done = lv;
    e_hit  = lv && (lk != 2'd3) && m_vld[s] && m_opc[s] == lo &&
             m_a[s] == la && m_b[s] == lb;
    e_res  = e_hit ? m_res[s] : '0;
    e_tag  = tag;
    if (rv && rk != 2'd3) begin
      s = tb_slot(ra, rb);
      m_vld[s] = 1'b1; m_opc[s] = ro; m_a[s] = ra; m_b[s] = rb; m_res[s] = rr;
    end
    lk_valid = lv; lk_kind = lk; lk_opc = lo; lk_a = la; lk_b = lb;
    rg_valid = rv; rg_kind = rk; rg_opc = ro; rg_a = ra; rg_b = rb; rg_result = rr;
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_pending();
    rst = 1'b1;
    lk_valid = 1'b0; rg_valid = 1'b0;
    model_clear();
    e_done = 1'b0; e_hit = 1'b0; e_res = '0; e_tag = "R1";
    repeat (2) begin
      @(negedge clk);
      check_pending();
    end
    rst = 1'b0;
  endtask

  task automatic lkp(input logic [1:0] k, input logic [OPC_W-1:0] o,
                     input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                     input string tag);
    step(1'b1, k, o, a, b, 1'b0, 2'd0, '0, '0, '0, '0, tag);
  endtask

  task automatic reg_only(input logic [1:0] k, input logic [OPC_W-1:0] o,
                          input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b,
                          input logic [DATA_W-1:0] r, input string tag);
    step(1'b0, 2'd0, '0, '0, '0, 1'b1, k, o, a, b, r, tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] pa [8];
    logic [DATA_W-1:0] pb [8];
    int unsigned seed;
    seed = $urandom(32'd2024);
    model_clear();
    do_reset();

    // R1: nothing stored after reset
    lkp(2'd0, 6'd5, 32'd10, 32'd20, "R1");
    // R2: idle cycle
    step(1'b0, 2'd0, '0, '0, '0, 1'b0, 2'd0, '0, '0, '0, '0, "R2");
    // R4: store then exact hit
    reg_only(2'd0, 6'd5, 32'd10, 32'd20, 32'd30, "R4");
    lkp(2'd0, 6'd5, 32'd10, 32'd20, "R4");
    lkp(2'd0, 6'd6, 32'd10, 32'd20, "R4");
    lkp(2'd0, 6'd5, 32'h8000_000A, 32'h8000_0014, "R4");
    lkp(2'd0, 6'd5, 32'd10, 32'h0001_0014, "R5");
    // R7: branch lookup of a stored key misses
    lkp(2'd3, 6'd5, 32'd10, 32'd20, "R7");
    // R6: branch registration ignored; load/store recorded
    reg_only(2'd3, 6'd7, 32'd1, 32'd2, 32'd3, "R6");
    lkp(2'd0, 6'd7, 32'd1, 32'd2, "R6");
    reg_only(2'd1, 6'd8, 32'h100, 32'h4, 32'h104, "R6");
    reg_only(2'd2, 6'd9, 32'h200, 32'h8, 32'h208, "R6");
    lkp(2'd1, 6'd8, 32'h100, 32'h4, "R6");
    lkp(2'd2, 6'd9, 32'h200, 32'h8, "R6");
    // R3: neighbouring keys in distinct slots both hit
    reg_only(2'd0, 6'd5, 32'd11, 32'd20, 32'd31, "R3");
    lkp(2'd0, 6'd5, 32'd11, 32'd20, "R3");
    lkp(2'd0, 6'd5, 32'd10, 32'd20, "R3");
    // R8: aliasing key evicts
    reg_only(2'd0, 6'd5, 32'h0000_010A, 32'h0000_0114, 32'd77, "R8");
    lkp(2'd0, 6'd5, 32'd10, 32'd20, "R8");
    lkp(2'd0, 6'd5, 32'h0000_010A, 32'h0000_0114, "R8");
    // R9: same-cycle write and read of one slot returns old contents
    step(1'b1, 2'd0, 6'd5, 32'h0000_010A, 32'h0000_0114,
         1'b1, 2'd0, 6'd5, 32'h0000_020A, 32'h0000_0214, 32'd88, "R9");
    lkp(2'd0, 6'd5, 32'h0000_020A, 32'h0000_0214, "R9");
    lkp(2'd0, 6'd5, 32'h0000_010A, 32'h0000_0114, "R9");
    // R1: reset mid-run drops entries
    do_reset();
    lkp(2'd0, 6'd5, 32'h0000_020A, 32'h0000_0214, "R1");
    lkp(2'd2, 6'd9, 32'h200, 32'h8, "R1");

    // Random mix over small operand pools
    for (int i = 0; i < 8; i++) begin
      pa[i] = $urandom;
      pb[i] = (i < 4) ? (pa[i] ^ 32'h0000_0F00) : $urandom;
    end
    for (int n = 0; n < 4000; n++) begin
      int ia, ib, ja, jb;
      ia = $urandom_range(0, 7); ib = $urandom_range(0, 7);
      ja = $urandom_range(0, 7); jb = $urandom_range(0, 7);
      step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
           6'($urandom_range(0, 3)), pa[ia], pb[ib],
           $urandom_range(0, 2) == 0, 2'($urandom_range(0, 3)),
           6'($urandom_range(0, 3)), pa[ja], pb[jb], $urandom, "R4");
    end
    @(negedge clk);
    check_pending();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule